// File: doc/BRIEF.md
# Bit-Configurable GPIO Port with Edge Interrupts

This block is one general-purpose I/O port of a configurable width. The default is eight pins. It sits behind a byte-wide register interface: an address, a write strobe, write data and combinational read data. Each pin has its own settings for direction, output level, pull control, edge polarity and interrupt enable. The block drives the pad output value, the pad output enable and the pull request lines. It raises a single interrupt request.

Pad inputs pass through a two-flop synchroniser. The synchronised levels are then compared with their values one cycle earlier to find edges. When a pin sees the edge its polarity bit selects, the pin's flag latches. Software can also set flags by writing the flag register, and only software clears them. If a hardware edge and a software clear hit the same bit in the same cycle, the edge is kept. The pull lines are only requests to the pad ring; the resistors themselves sit outside this block.

Register map: address 0 is the pin levels (read-only), 1 the output value, 2 the direction, 3 the pull enable, 4 the interrupt enable, 5 the edge polarity and 6 the flags. Address 7 is unused.

Top module: `gpio_edge_port`

## Requirements
- R1: A 1 written to a bit of the direction register (address 2) drives that bit of `pad_oe` high, making the pin an output. A 0 makes the pin an input. The register reads back what was written.
- R2: Address 0 returns the pin levels two clock edges after the pins change. Writes to address 0 are ignored.
- R3: The output register (address 1) reads back its last written value and drives `pad_out`, so read-modify-write sequences work.
- R4: A pin's flag bit sets three clock edges after the pin changes, provided the change matches the pin's polarity bit (address 5). Polarity 0 means a low-to-high transition sets the flag; polarity 1 means high-to-low. A transition of the other direction leaves the flag unchanged.
- R5: Writing the flag register (address 6) loads its value, so software can both set and clear flags. Without such a write, a flag that is set stays set.
- R6: `irq` is high exactly when some flag bit and the matching interrupt-enable bit (address 4) are both 1.
- R7: `pull_en` is high for a bit whose pull-enable bit (address 3) is 1 while its direction bit is 0. `pull_up` carries the output register, where 1 means pull up and 0 means pull down.
- R8: If an edge and a software write of 0 reach the same flag bit in the same cycle, the flag ends up set.
- R9: After reset, every register reads 0, all outputs are 0 and `irq` is low.
- R10: Reading the unused address 7 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe for the addressed register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| pin_in | input | 8 | Asynchronous pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| pull_en | output | 8 | Pull request per pin |
| pull_up | output | 8 | Pull direction per pin (1 up, 0 down) |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default width of eight pins and the three-bit address, so all seven registers and the unused address are reachable. At that width, mixed patterns can be used. Alternating and half-set bytes show that direction, pull and polarity act per bit and never leak between pins. Opposite edges on neighbouring pins, together with the single cycle in which an edge meets a clear, bring the polarity rule and the edge-wins rule within reach.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int unsigned PORT_AW = 3;

    typedef enum logic [PORT_AW-1:0] {
        REG_LEVEL = 3'd0,
        REG_OUT   = 3'd1,
        REG_DIR   = 3'd2,
        REG_PULL  = 3'd3,
        REG_IEN   = 3'd4,
        REG_POL   = 3'd5,
        REG_FLAG  = 3'd6,
        REG_NONE  = 3'd7
    } port_addr_e;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    input  logic [W-1:0] pol_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] hit_o
);

    typedef struct packed {
        logic [W-1:0] stage1;
        logic [W-1:0] stage2;
        logic [W-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;
    logic [W-1:0] rise_w, fall_w;

    always_comb begin
        st_d        = st_q;
        st_d.stage1 = pin_i;
        st_d.stage2 = st_q.stage1;
        st_d.prev   = st_q.stage2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < W; i++) begin : g_edge
        assign rise_w[i] =  st_q.stage2[i] & ~st_q.prev[i];
        assign fall_w[i] = ~st_q.stage2[i] &  st_q.prev[i];
        assign hit_o[i]  = pol_i[i] ? fall_w[i] : rise_w[i];
    end

    assign level_o = st_q.stage2;

endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_port_pkg::*;
#(
    parameter int unsigned W  = 8,
    parameter int unsigned AW = PORT_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic [W-1:0]  wdata_i,
    output logic [W-1:0]  dir_o,
    output logic [W-1:0]  out_o,
    output logic [W-1:0]  pull_o,
    output logic [W-1:0]  ien_o,
    output logic [W-1:0]  pol_o,
    output logic          flag_wr_o
);

    typedef struct packed {
        logic [W-1:0] dir;
        logic [W-1:0] out;
        logic [W-1:0] pull;
        logic [W-1:0] ien;
        logic [W-1:0] pol;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d     = cfg_q;
        flag_wr_o = 1'b0;
        if (wr_i) begin
            case (port_addr_e'(addr_i))
                REG_OUT:  cfg_d.out  = wdata_i;
                REG_DIR:  cfg_d.dir  = wdata_i;
                REG_PULL: cfg_d.pull = wdata_i;
                REG_IEN:  cfg_d.ien  = wdata_i;
                REG_POL:  cfg_d.pol  = wdata_i;
                REG_FLAG: flag_wr_o  = 1'b1;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign dir_o  = cfg_q.dir;
    assign out_o  = cfg_q.out;
    assign pull_o = cfg_q.pull;
    assign ien_o  = cfg_q.ien;
    assign pol_o  = cfg_q.pol;

    AST_DIR_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == REG_DIR) |=> (dir_o == $past(wdata_i))); // R1

    AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && addr_i == REG_OUT) |=> $stable(out_o)); // R3

endmodule

// File: rtl/gpio_flag_bank.sv
module gpio_flag_bank #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic [W-1:0] hit_i,
    input  logic [W-1:0] ien_i,
    output logic [W-1:0] flag_o,
    output logic         irq_o
);

    typedef struct packed {
        logic [W-1:0] flag;
    } flag_t;

    flag_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (wr_i) fl_d.flag = wdata_i;
        // a detected edge overrides a same-cycle software clear
        fl_d.flag = fl_d.flag | hit_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign flag_o = fl_q.flag;
    assign irq_o  = |(fl_q.flag & ien_i);

    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i != '0) |=> ((flag_o & $past(hit_i)) == $past(hit_i))); // R4

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> ((flag_o & $past(flag_o)) == $past(flag_o))); // R5

    AST_NO_SPURIOUS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> ((flag_o & ~$past(flag_o) & ~$past(hit_i)) == '0)); // R4

endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
    import gpio_port_pkg::*;
#(
    parameter int unsigned W  = 8,
    parameter int unsigned AW = PORT_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    input  logic [W-1:0]  pin_in,
    output logic [W-1:0]  pad_out,
    output logic [W-1:0]  pad_oe,
    output logic [W-1:0]  pull_en,
    output logic [W-1:0]  pull_up,
    output logic          irq
);

    logic [W-1:0] dir_w, out_w, pull_w, ien_w, pol_w;
    logic [W-1:0] level_w, hit_w, flag_w;
    logic         flag_wr_w;

    gpio_cfg_regs #(.W(W), .AW(AW)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (wr_en),
        .addr_i    (addr),
        .wdata_i   (wdata),
        .dir_o     (dir_w),
        .out_o     (out_w),
        .pull_o    (pull_w),
        .ien_o     (ien_w),
        .pol_o     (pol_w),
        .flag_wr_o (flag_wr_w)
    );

    gpio_in_sync #(.W(W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (pin_in),
        .pol_i   (pol_w),
        .level_o (level_w),
        .hit_o   (hit_w)
    );

    gpio_flag_bank #(.W(W)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (flag_wr_w),
        .wdata_i (wdata),
        .hit_i   (hit_w),
        .ien_i   (ien_w),
        .flag_o  (flag_w),
        .irq_o   (irq)
    );

    always_comb begin
        case (port_addr_e'(addr))
            REG_LEVEL: rdata = level_w;
            REG_OUT:   rdata = out_w;
            REG_DIR:   rdata = dir_w;
            REG_PULL:  rdata = pull_w;
            REG_IEN:   rdata = ien_w;
            REG_POL:   rdata = pol_w;
            REG_FLAG:  rdata = flag_w;
            default:   rdata = '0;
        endcase
    end

    assign pad_out = out_w;
    assign pad_oe  = dir_w;
    assign pull_en = pull_w & ~dir_w;
    assign pull_up = out_w;

    AST_PULL_INPUT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ((pull_en & pad_oe) == '0)); // R7

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((flag_w & ien_w) != '0)); // R6

endmodule

// File: tb/gpio_edge_port_test.sv
`timescale 1ns/1ps
module gpio_edge_port_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] pin_in = '0;
    logic [7:0] pad_out, pad_oe, pull_en, pull_up;
    logic       irq;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_edge_port uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .pin_in(pin_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pull_en(pull_en), .pull_up(pull_up), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [2:0] a, input logic [7:0] exp);
        addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // {write, addr, data, expected read}
    localparam int NV = 14;
    localparam logic [19:0] VEC [0:NV-1] = '{
        {1'b1, 3'd1, 8'hA5, 8'h00},
        {1'b0, 3'd1, 8'h00, 8'hA5},
        {1'b1, 3'd2, 8'h0F, 8'h00},
        {1'b0, 3'd2, 8'h00, 8'h0F},
        {1'b1, 3'd3, 8'hF0, 8'h00},
        {1'b0, 3'd3, 8'h00, 8'hF0},
        {1'b1, 3'd4, 8'h3C, 8'h00},
        {1'b0, 3'd4, 8'h00, 8'h3C},
        {1'b1, 3'd5, 8'h81, 8'h00},
        {1'b0, 3'd5, 8'h00, 8'h81},
        {1'b1, 3'd0, 8'hFF, 8'h00},
        {1'b0, 3'd0, 8'h00, 8'h00},
        {1'b1, 3'd7, 8'h5A, 8'h00},
        {1'b0, 3'd7, 8'h00, 8'h00}
    };

    initial begin
        wait_cycles(3);
        // R9 reset state
        for (int a = 0; a < 8; a++) rd_check("R9 reg", 3'(a), 8'h00);
        check("R9 pad_oe", pad_oe, 8'h00);
        check("R9 irq", {7'b0, irq}, 8'h00);
        @(negedge clk) rst_n = 1'b1;
        wait_cycles(1);

        // R1 R2 R3 R10 register table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][19]) wr(VEC[i][18:16], VEC[i][15:8]);
            else rd_check("R1/R2/R3/R10 table", VEC[i][18:16], VEC[i][7:0]);
        end
        check("R1 pad_oe", pad_oe, 8'h0F);
        check("R3 pad_out", pad_out, 8'hA5);
        check("R7 pull_en", pull_en, 8'hF0);
        check("R7 pull_up", pull_up, 8'hA5);
        wr(3'd2, 8'hFF);
        check("R7 pull masked by output", pull_en, 8'h00);

        // clear configuration for the edge tests
        wr(3'd5, 8'h02);
        wr(3'd4, 8'hFF);
        wr(3'd6, 8'h00);
        wait_cycles(2);
        rd_check("R5 cleared", 3'd6, 8'h00);

        // R2 synchroniser latency, R4 rising edge on bit0, rise on bit1 ignored
        @(negedge clk) pin_in = 8'h03;
        @(negedge clk);
        rd_check("R2 level after one edge", 3'd0, 8'h00);
        @(negedge clk);
        rd_check("R2 level after two edges", 3'd0, 8'h03);
        rd_check("R4 flag not yet set", 3'd6, 8'h00);
        @(negedge clk);
        rd_check("R4 rise sets bit0 only", 3'd6, 8'h01);
        check("R6 irq high", {7'b0, irq}, 8'h01);

        // R4 falling edge on bit1, fall on bit0 ignored
        @(negedge clk) pin_in = 8'h00;
        wait_cycles(3);
        rd_check("R4 fall sets bit1", 3'd6, 8'h03);
        wait_cycles(4);
        rd_check("R5 flags stay set", 3'd6, 8'h03);

        // R5 software clear and software set, R6 enable gating
        wr(3'd6, 8'h00);
        rd_check("R5 software clear", 3'd6, 8'h00);
        check("R6 irq low after clear", {7'b0, irq}, 8'h00);
        wr(3'd4, 8'h00);
        wr(3'd6, 8'h80);
        rd_check("R5 software set", 3'd6, 8'h80);
        check("R6 irq masked", {7'b0, irq}, 8'h00);
        wr(3'd4, 8'h80);
        check("R6 irq enabled", {7'b0, irq}, 8'h01);
        wr(3'd6, 8'h00);

        // R8 edge on bit2 coincides with a software clear
        @(negedge clk) pin_in = 8'h04;
        @(negedge clk);
        @(negedge clk);
        addr = 3'd6; wdata = 8'h00; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        rd_check("R8 edge beats clear", 3'd6, 8'h04);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule